// File: doc/BRIEF.md
# Bank Command Filter and In-Order Request Queue

This block sits beside one memory bank on a shared system bus. Every bus cycle that carries a command word is decoded. The block decides whether the command belongs to this bank and how many 64-bit data words follow it on the next valid bus cycles. Only accepted command words and the data words behind them are written into an in-order queue. All other traffic passes by untouched: foreign commands, unknown opcodes, their payloads and stray data words.

A downstream command decoder takes work from the queue one whole command at a time. A command appears on the output only after all of its data words are in the queue. One pop removes the command word together with its data. The block watches the free space in the queue. When the free space could not take one more command of the largest size, it asks the bus arbiter to hold off new requests.

A small configuration port sets the memory region tag, the IO region tag, and the bank number with the count of bank-select bits. Commands are refused until both region tags have been written.

Top module: `bus_cmd_queue`

## Requirements
- R1: After reset, `cmd_valid_o` and `stop_o` are 0. Every command is ignored until both the memory tag (`cfg_sel_i`=0) and the IO tag (`cfg_sel_i`=1) have been written.
- R2: The opcode is `bus_word_i[63:61]`. The data words that follow each opcode are: 0 block read → 0, 1 block write → 4, 2 single write → 1, 3 IO read → 0, 4 broadcast IO write → 1. `cmd_ndata_o` reports this count for the head command.
- R3: A memory command (opcodes 0, 1 and 2) is accepted only when both of these hold:
  - address bits `bus_word_i[31:28]` equal the memory tag;
  - address bits [5:2] equal the programmed bank number in the bank-select bits.
- R4: An IO read is accepted only when address bits [31:28] equal the IO tag and the bank bits match. A broadcast IO write is accepted whatever its address.
- R5: The following never enter the queue:
  - commands with opcodes 5 to 7;
  - commands that fail their match, together with their data words;
  - data words that arrive when no data is owed.
- R6: Commands leave the queue in arrival order. The head word stays stable until it is popped.
- R7: `cmd_valid_o` is 1 only when the head command and all of its data words are present. `cmd_data_o[64*k+63:64*k]` holds data word k.
- R8: `cmd_pop_i` while `cmd_valid_o` is 1 removes the head command and its data words in one cycle.
- R9: `stop_o` is 1 exactly when the occupancy exceeds DEPTH-5, so the queue never overflows.
- R10: The bank config write (`cfg_sel_i`=2) works as follows:
  - `cfg_data_i[3:0]` gives the bank number;
  - `cfg_data_i[7:4]` gives the number of bank-select bits, clamped to 4, so up to 16 banks;
  - with 0 bits, every bank number matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select: 0 memory tag, 1 IO tag, 2 bank |
| cfg_data_i | input | 8 | Configuration write data |
| bus_valid_i | input | 1 | Bus word valid this cycle |
| bus_cmd_i | input | 1 | Bus word is a command word |
| bus_word_i | input | 64 | Bus word |
| stop_o | output | 1 | Hold request to the arbiter |
| cmd_valid_o | output | 1 | Whole head command available |
| cmd_word_o | output | 64 | Head command word |
| cmd_ndata_o | output | 3 | Data word count of the head command |
| cmd_data_o | output | 256 | Data words of the head command, word k at bits 64k+63:64k |
| cmd_pop_i | input | 1 | Remove the head command and its data |

## Verification
A wrong remaining-word counter in the filter shows within one bus transfer:
- If it drops a data word, `cmd_valid_o` never rises for that command.
- If it admits a stray word, the next popped command word carries a data value instead of an opcode.

A wrong occupancy or read pointer appears at the first pop, as a head word or data word that differs from the arrival order. `stop_o` is checked on the cycle the occupancy crosses the threshold. The gating on configuration and the bank mask are checked by commands that would be accepted under any other setting.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  localparam int WORD_W   = 64;
  localparam int MAX_DATA = 4;

  typedef enum logic [2:0] {
    OP_BLK_RD  = 3'd0,
    OP_BLK_WR  = 3'd1,
    OP_ONE_WR  = 3'd2,
    OP_IO_RD   = 3'd3,
    OP_IO_BCST = 3'd4
  } op_e;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic [2:0] op_ndata(input logic [2:0] op);
    case (op)
      OP_BLK_WR:  return 3'd4;
      OP_ONE_WR:  return 3'd1;
      OP_IO_BCST: return 3'd1;
      default:    return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/bcq_cfg.sv
module bcq_cfg #(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [7:0]       data_i,
  output logic [TAG_W-1:0] mem_tag_o,
  output logic [TAG_W-1:0] io_tag_o,
  output logic [3:0]       bank_id_o,
  output logic [3:0]       bank_mask_o,
  output logic             ready_o
);
  logic       mem_set_q, io_set_q;
  logic [2:0] lg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_tag_o <= '0;
      io_tag_o  <= '0;
      bank_id_o <= '0;
      lg_q      <= '0;
      mem_set_q <= 1'b0;
      io_set_q  <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        2'd0: begin mem_tag_o <= data_i[TAG_W-1:0]; mem_set_q <= 1'b1; end
        2'd1: begin io_tag_o  <= data_i[TAG_W-1:0]; io_set_q  <= 1'b1; end
        2'd2: begin
          bank_id_o <= data_i[3:0];
          lg_q      <= (data_i[7:4] > 4'd4) ? 3'd4 : data_i[6:4];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) bank_mask_o[i] = (3'(i) < lg_q);
  end

  assign ready_o = mem_set_q & io_set_q;
endmodule

// File: rtl/bcq_filter.sv
module bcq_filter
  import bcq_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic [TAG_W-1:0]  mem_tag_i,
  input  logic [TAG_W-1:0]  io_tag_i,
  input  logic [3:0]        bank_id_i,
  input  logic [3:0]        bank_mask_i,
  input  logic              bus_valid_i,
  input  logic              bus_cmd_i,
  input  logic [WORD_W-1:0] bus_word_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  logic [2:0]       op, rem_q;
  logic             keep_q, tag_mem, tag_io, bank_hit, hit;
  logic [TAG_W-1:0] tag;

  assign op       = bus_word_i[WORD_W-1 -: 3];
  assign tag      = bus_word_i[ADDR_W-1 -: TAG_W];
  assign tag_mem  = (tag == mem_tag_i);
  assign tag_io   = (tag == io_tag_i);
  assign bank_hit = ((bus_word_i[BLK_LSB +: 4] ^ bank_id_i) & bank_mask_i) == 4'd0;

  always_comb begin
    case (op)
      OP_BLK_RD, OP_BLK_WR, OP_ONE_WR: hit = tag_mem & bank_hit;
      OP_IO_RD:                        hit = tag_io & bank_hit;
      OP_IO_BCST:                      hit = 1'b1;
      default:                         hit = 1'b0;
    endcase
    hit = hit & ready_i & op_known(op);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      keep_q <= 1'b0;
    end else if (bus_valid_i) begin
      if (bus_cmd_i) begin
        rem_q  <= op_known(op) ? op_ndata(op) : 3'd0;
        keep_q <= hit;
      end else if (rem_q != 3'd0) begin
        rem_q  <= rem_q - 3'd1;
      end
    end
  end

  assign push_o = bus_valid_i & (bus_cmd_i ? hit : (rem_q != 3'd0) & keep_q);
  assign word_o = bus_word_i;
endmodule

// File: rtl/bcq_fifo.sv
module bcq_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int RD_N  = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [W-1:0]           wdata_i,
  input  logic                   pop_i,
  input  logic [2:0]             pop_n_i,
  output logic [RD_N-1:0][W-1:0] rdata_o,
  output logic [CW-1:0]          count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          do_push;

  assign do_push = push_i & (count_o != CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (pop_i)   rd_q <= rd_q + AW'(pop_n_i);
      count_o <= count_o + CW'(do_push) - (pop_i ? CW'(pop_n_i) : CW'(0));
    end
  end

  for (genvar k = 0; k < RD_N; k++) begin : g_rd
    assign rdata_o[k] = mem_q[rd_q + AW'(k)];
  end
endmodule

// File: rtl/bus_cmd_queue.sv
module bus_cmd_queue
  import bcq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 4,
  parameter int ADDR_W  = 32,
  parameter int BLK_LSB = 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORST  = 1 + MAX_DATA
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [1:0]                 cfg_sel_i,
  input  logic [7:0]                 cfg_data_i,
  input  logic                       bus_valid_i,
  input  logic                       bus_cmd_i,
  input  logic [WORD_W-1:0]          bus_word_i,
  output logic                       stop_o,
  output logic                       cmd_valid_o,
  output logic [WORD_W-1:0]          cmd_word_o,
  output logic [2:0]                 cmd_ndata_o,
  output logic [MAX_DATA*WORD_W-1:0] cmd_data_o,
  input  logic                       cmd_pop_i
);
  logic [TAG_W-1:0] mem_tag, io_tag;
  logic [3:0]       bank_id, bank_mask;
  logic             cfg_ready, push;
  logic [WORD_W-1:0] push_word;
  logic [MAX_DATA:0][WORD_W-1:0] head;
  logic [CW-1:0]    fifo_count;
  logic             pop;

  bcq_cfg #(.TAG_W(TAG_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .mem_tag_o(mem_tag), .io_tag_o(io_tag), .bank_id_o(bank_id),
    .bank_mask_o(bank_mask), .ready_o(cfg_ready)
  );

  bcq_filter #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_filter (
    .clk_i, .rst_ni, .ready_i(cfg_ready), .mem_tag_i(mem_tag), .io_tag_i(io_tag),
    .bank_id_i(bank_id), .bank_mask_i(bank_mask), .bus_valid_i, .bus_cmd_i,
    .bus_word_i, .push_o(push), .word_o(push_word)
  );

  bcq_fifo #(.W(WORD_W), .DEPTH(DEPTH), .RD_N(MAX_DATA + 1)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(push_word), .pop_i(pop),
    .pop_n_i(3'd1 + cmd_ndata_o), .rdata_o(head), .count_o(fifo_count)
  );

  assign cmd_word_o  = head[0];
  assign cmd_ndata_o = op_ndata(head[0][WORD_W-1 -: 3]);
  // head is always a command word: only accepted commands precede their data
  assign cmd_valid_o = (fifo_count != '0) && (fifo_count > CW'(cmd_ndata_o));
  assign pop         = cmd_pop_i & cmd_valid_o;
  assign stop_o      = fifo_count > CW'(DEPTH - WORST);

  for (genvar k = 0; k < MAX_DATA; k++) begin : g_data
    assign cmd_data_o[k*WORD_W +: WORD_W] = (3'(k) < cmd_ndata_o) ? head[k+1] : '0;
  end
endmodule

// File: rtl/bus_cmd_queue_chk.sv
module bus_cmd_queue_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_ready,
  input logic          push,
  input logic [CW-1:0] fifo_count,
  input logic          cmd_valid_o,
  input logic          cmd_pop_i,
  input logic [2:0]    cmd_ndata_o,
  input logic [63:0]   cmd_word_o,
  input logic          stop_o
);
  a_r1_idle_until_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready |-> fifo_count == '0);
  a_r2_known_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_word_o[63:61] <= 3'd4);
  a_r6_stable_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_pop_i |=> cmd_valid_o && $stable(cmd_word_o));
  a_r7_whole_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> int'(fifo_count) >= 1 + int'(cmd_ndata_o));
  a_r8_pop_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_pop_i && !push |=>
      int'(fifo_count) == int'($past(fifo_count)) - 1 - int'($past(cmd_ndata_o)));
  a_r9_stop_margin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_o |-> DEPTH - int'(fifo_count) >= 5);
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_count) <= DEPTH);
endmodule

bind bus_cmd_queue bus_cmd_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .cfg_ready, .push, .fifo_count, .cmd_valid_o,
  .cmd_pop_i, .cmd_ndata_o, .cmd_word_o, .stop_o
);

// File: tb/bus_cmd_queue_bench.sv
module bus_cmd_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BW = 64'h2000_0000_A000_0014;

  typedef struct packed {
    logic        c;
    logic [63:0] w;
    logic [63:0] head;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{1'b1, 64'h0000_0000_A000_0008, 64'h0},
    '{1'b1, 64'h2000_0000_B000_0004, 64'h0},
    '{1'b0, 64'hDEAD_0001, 64'h0},
    '{1'b0, 64'hDEAD_0002, 64'h0},
    '{1'b0, 64'hDEAD_0003, 64'h0},
    '{1'b0, 64'hDEAD_0004, 64'h0},
    '{1'b0, 64'h0BAD, 64'h0},
    '{1'b1, 64'hC000_0000_A000_0004, 64'h0},
    '{1'b1, 64'h6000_0000_A000_0004, 64'h0},
    '{1'b1, BW, 64'h0},
    '{1'b0, 64'h11, 64'h0},
    '{1'b0, 64'h22, 64'h0},
    '{1'b0, 64'h33, 64'h0},
    '{1'b0, 64'h44, BW},
    '{1'b1, 64'h0000_0000_A000_0004, BW},
    '{1'b1, 64'h6000_0000_3000_0004, BW},
    '{1'b1, 64'h8000_0000_5000_0000, BW},
    '{1'b0, 64'h66, BW},
    '{1'b1, 64'h4000_0000_A000_0044, BW},
    '{1'b0, 64'h77, BW}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, bus_valid = 0, bus_cmd = 0, cmd_pop = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_data = 0;
  logic [63:0] bus_word = 0;
  logic stop, cmd_valid;
  logic [63:0] cmd_word;
  logic [2:0] cmd_ndata;
  logic [255:0] cmd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_queue u_bus_cmd_queue (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .bus_valid_i(bus_valid), .bus_cmd_i(bus_cmd),
    .bus_word_i(bus_word), .stop_o(stop), .cmd_valid_o(cmd_valid),
    .cmd_word_o(cmd_word), .cmd_ndata_o(cmd_ndata), .cmd_data_o(cmd_data),
    .cmd_pop_i(cmd_pop)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic bus(input logic c, input logic [63:0] w);
    @(negedge clk); bus_valid = 1; bus_cmd = c; bus_word = w;
    @(negedge clk); bus_valid = 0; bus_cmd = 0;
  endtask

  // check head command, then pop it
  task automatic take(input string req, input logic [63:0] w, input logic [2:0] n,
                      input logic [63:0] d0, input logic [63:0] d3);
    chk({req, " valid"}, 64'(cmd_valid), 64'd1);
    chk({req, " word"}, cmd_word, w);
    chk({req, " ndata"}, 64'(cmd_ndata), 64'(n));
    if (n != 0) chk({req, " data0"}, cmd_data[63:0], d0);
    if (n == 4) chk({req, " data3"}, cmd_data[255:192], d3);
    cmd_pop = 1;
    @(negedge clk); cmd_pop = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(cmd_valid), 64'd0);
    chk("R1 reset stop", 64'(stop), 64'd0);
    rst_n = 1;
    bus(1'b1, 64'h0000_0000_A000_0004);
    chk("R1 unconfigured ignored", 64'(cmd_valid), 64'd0);
    cfg(2'd0, 8'h0A);
    bus(1'b1, 64'h0000_0000_A000_0004);
    chk("R1 io tag missing ignored", 64'(cmd_valid), 64'd0);
    cfg(2'd1, 8'h03);
    cfg(2'd2, 8'h21); // two bank bits, bank 1
    for (int i = 0; i < 20; i++) begin
      bus(VEC[i].c, VEC[i].w);
      chk($sformatf("R3 R5 R7 vec%0d valid", i), 64'(cmd_valid), 64'(VEC[i].head != 0));
      if (VEC[i].head != 0) chk($sformatf("R6 vec%0d head", i), cmd_word, VEC[i].head);
    end
    chk("R9 stop below threshold", 64'(stop), 64'd0);
    bus(1'b1, 64'h0000_0000_A000_0004);
    chk("R9 stop above threshold", 64'(stop), 64'd1);
    take("R2 R8 block write", BW, 3'd4, 64'h11, 64'h44);
    chk("R9 stop released", 64'(stop), 64'd0);
    take("R3 block read", 64'h0000_0000_A000_0004, 3'd0, 0, 0);
    take("R4 io read", 64'h6000_0000_3000_0004, 3'd0, 0, 0);
    take("R4 broadcast", 64'h8000_0000_5000_0000, 3'd1, 64'h66, 0);
    take("R6 single write", 64'h4000_0000_A000_0044, 3'd1, 64'h77, 0);
    take("R6 last read", 64'h0000_0000_A000_0004, 3'd0, 0, 0);
    chk("R8 empty after pops", 64'(cmd_valid), 64'd0);
    cfg(2'd2, 8'h49); // four bank bits, bank 9
    bus(1'b1, 64'h0000_0000_A000_0004);
    chk("R10 bank 1 rejected", 64'(cmd_valid), 64'd0);
    bus(1'b1, 64'h0000_0000_A000_0064);
    take("R10 bank 9 accepted", 64'h0000_0000_A000_0064, 3'd0, 0, 0);
    chk("R10 nothing extra", 64'(cmd_valid), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule